// File: doc/BRIEF.md
# Command-Indexed Cartridge Bank Mapper with Scanline IRQ Counter

This block translates CPU and PPU address bits into banked ROM addresses for a cartridge. Software first writes a command number to a select register. The next write to the paired data register loads a bank number into the one of eight bank registers that the command names. Six of those registers map character (CHR) memory: two 2 KB windows and four 1 KB windows. The other two map 8 KB program (PRG) windows. Two mode bits in the select value change the layout. One moves the switchable PRG window between $8000 and $C000. The other exchanges the two 4 KB halves of the CHR space.

A write decoder also sets a mirroring bit and a save-RAM enable. It also drives a reloadable 8-bit down-counter that is clocked once per scanline by an external pulse. When that counter reaches zero while interrupts are enabled, the IRQ line asserts. It stays asserted until software acknowledges it. All outputs are registered. The bank numbers reflect the addresses presented one clock earlier.

Top module: `cmd_bank_mapper`

## Requirements
- R1: Synchronous active-high reset clears every output to 0, including irq, and clears all bank registers, the mode bits, the counter and the reload latch.
- R2: Writes are decoded by `{cpu_ahi[1:0], cpu_a0}` only when cpu_ahi[2] (A15) is 1. At $8000 (cpu_ahi=3'b100, cpu_a0=0), wr_data[2:0] picks a command. At $8001 (cpu_a0=1), wr_data is loaded into the bank register of that command, and the other bank registers are left unchanged.
- R3: The PPU index is `ppu_ahi` (A12..A10), with 1 KB granularity. Command 0 covers indices 0–1 and command 1 covers indices 2–3. In each of these 2 KB windows, bit 0 of the stored bank number is replaced by A10.
- R4: Commands 2, 3, 4 and 5 each cover a single 1 KB index, 4, 5, 6 and 7 respectively. When bit 7 of the last $8000 value is 1, A12 is inverted before the lookup, so the two 4 KB halves trade places.
- R5: The CPU window is `cpu_ahi[1:0]` with A15 = 1. With bit 6 of the last $8000 value at 0, window $8000 maps the command-6 bank, $A000 maps the command-7 bank, $C000 maps the second-to-last bank (2^PRG_BW − 2) and $E000 maps the last bank (2^PRG_BW − 1). With bit 6 at 1, the command-6 bank moves to $C000 and $8000 maps the second-to-last bank. PRG banks take the low PRG_BW bits of the stored value.
- R6: prg_bank and chr_bank are registered. They show the mapping of the address presented at the previous rising clock edge.
- R7: A write to $A000 (cpu_ahi=3'b101, cpu_a0=0) sets mirror_vert from wr_data[1]; the other data bits have no effect. A write to $A001 sets sram_en from wr_data[7].
- R8: A write to $C000 (3'b110, a0=0) loads the counter. A write to $C001 loads the reload latch. A write to $E000 (3'b111, a0=0) copies the latch into the counter and disables IRQ generation. On each scan_pulse without a counter write, the counter reloads from the latch if it is zero and otherwise decrements.
- R9: A write to $E001 enables IRQ generation. When a scan_pulse leaves the counter at zero while IRQs are enabled, irq asserts on the next cycle. irq stays asserted until a write to $E000 clears it, and it never rises without a scan_pulse.
- R10: A write with cpu_ahi[2]=0 changes no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | CPU write strobe, one cycle per write |
| cpu_ahi | input | 3 | CPU address A15..A13 |
| cpu_a0 | input | 1 | CPU address A0 |
| wr_data | input | 8 | CPU write data |
| ppu_ahi | input | 3 | PPU address A12..A10 |
| scan_pulse | input | 1 | One-cycle counter clock, once per scanline |
| prg_bank | output | PRG_BW (6) | 8 KB PRG bank number |
| chr_bank | output | 8 | 1 KB CHR bank number |
| mirror_vert | output | 1 | 1 = vertical mirroring, 0 = horizontal |
| sram_en | output | 1 | Save-RAM enable for $6000–$7FFF |
| irq | output | 1 | Interrupt request, active high |

## Verification
The bank registers are filled with distinct values, including an odd number for command 0. This exposes a 2 KB window that fails to force its low bit, and any swap of one command's bank for another's. Each PRG and CHR index is then read back with both mode bits clear, and again with both set. Any error in window placement or in the half-swap shows up as a specific wrong bank number.

The counter is run through three sequences:
- A latch value counted down with IRQs enabled, which separates reload-at-zero from decrement-through-zero.
- A countdown with IRQs disabled, which must leave irq low.
- A direct counter load, which shows that a $C000 write acts without the latch.

Writes with A15 low, and a mirroring write with only bit 0 set, show whether ignored inputs leak into state.

// File: rtl/cbm_pkg.sv
package cbm_pkg;
  // Register select, encoded as {A14, A13, A0}
  typedef enum logic [2:0] {
    RS_CMD    = 3'b000,
    RS_DATA   = 3'b001,
    RS_MIRROR = 3'b010,
    RS_SRAM   = 3'b011,
    RS_CNT    = 3'b100,
    RS_LATCH  = 3'b101,
    RS_IRQOFF = 3'b110,
    RS_IRQON  = 3'b111
  } reg_sel_e;

  typedef struct packed {
    logic       prg_swap;  // switchable PRG window moves to $C000
    logic       chr_inv;   // CHR halves exchanged
    logic [2:0] cmd;       // bank register targeted by next data write
  } mode_t;

  localparam int NUM_BANKS = 8;
endpackage

// File: rtl/cbm_regs.sv
module cbm_regs
  import cbm_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [2:0]                    cpu_ahi,
  input  logic                          cpu_a0,
  input  logic [DW-1:0]                 wr_data,
  output mode_t                         mode_q,
  output logic [NUM_BANKS-1:0][DW-1:0]  banks_q,
  output logic                          mirror_q,
  output logic                          sram_q,
  output logic                          wr_cnt,
  output logic                          wr_latch,
  output logic                          wr_off,
  output logic                          wr_on
);
  logic     hit;
  reg_sel_e sel;

  assign hit = wr_en && cpu_ahi[2];
  assign sel = reg_sel_e'({cpu_ahi[1:0], cpu_a0});

  assign wr_cnt   = hit && (sel == RS_CNT);
  assign wr_latch = hit && (sel == RS_LATCH);
  assign wr_off   = hit && (sel == RS_IRQOFF);
  assign wr_on    = hit && (sel == RS_IRQON);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
    end else if (hit && sel == RS_CMD) begin
      mode_q.prg_swap <= wr_data[6];
      mode_q.chr_inv  <= wr_data[7];
      mode_q.cmd      <= wr_data[2:0];
    end
  end

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst)
        banks_q[i] <= '0;
      else if (hit && sel == RS_DATA && mode_q.cmd == 3'(i))
        banks_q[i] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mirror_q <= 1'b0;
      sram_q   <= 1'b0;
    end else begin
      if (hit && sel == RS_MIRROR) mirror_q <= wr_data[1];
      if (hit && sel == RS_SRAM)   sram_q   <= wr_data[7];
    end
  end
endmodule

// File: rtl/cbm_irq.sv
module cbm_irq #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_cnt,
  input  logic          wr_latch,
  input  logic          wr_off,
  input  logic          wr_on,
  input  logic [CW-1:0] din,
  input  logic          tick,
  output logic          irq
);
  logic [CW-1:0] cnt_q, latch_q, cnt_nx;
  logic          en_q;

  assign cnt_nx = (cnt_q == '0) ? latch_q : cnt_q - 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      latch_q <= '0;
      en_q    <= 1'b0;
      irq     <= 1'b0;
    end else begin
      if (wr_latch) latch_q <= din;
      if (wr_off) en_q <= 1'b0;
      else if (wr_on) en_q <= 1'b1;

      if (wr_off)      cnt_q <= latch_q;
      else if (wr_cnt) cnt_q <= din;
      else if (tick)   cnt_q <= cnt_nx;

      if (wr_off)
        irq <= 1'b0;
      else if (tick && !wr_cnt && cnt_nx == '0 && en_q)
        irq <= 1'b1;
    end
  end
endmodule

// File: rtl/cbm_xlate.sv
module cbm_xlate
  import cbm_pkg::*;
#(
  parameter int DW     = 8,
  parameter int PRG_BW = 6
) (
  input  logic                          clk,
  input  logic                          rst,
  input  mode_t                         mode,
  input  logic [NUM_BANKS-1:0][DW-1:0]  banks,
  input  logic [2:0]                    cpu_ahi,
  input  logic [2:0]                    ppu_ahi,
  output logic [PRG_BW-1:0]             prg_bank,
  output logic [DW-1:0]                 chr_bank
);
  localparam logic [PRG_BW-1:0] LAST_BANK = '1;
  localparam logic [PRG_BW-1:0] PENULT    = LAST_BANK - 1'b1;

  logic [2:0]        slot;
  logic [DW-1:0]     chr_d;
  logic [PRG_BW-1:0] prg_d, sw6, sw7;

  assign slot = ppu_ahi ^ {mode.chr_inv, 2'b00};
  assign sw6  = banks[6][PRG_BW-1:0];
  assign sw7  = banks[7][PRG_BW-1:0];

  always_comb begin
    if (!slot[2])
      chr_d = {banks[{2'b00, slot[1]}][DW-1:1], slot[0]};
    else
      chr_d = banks[3'({1'b0, slot[1:0]}) + 3'd2];
  end

  always_comb begin
    case (cpu_ahi[1:0])
      2'd0:    prg_d = mode.prg_swap ? PENULT : sw6;
      2'd1:    prg_d = sw7;
      2'd2:    prg_d = mode.prg_swap ? sw6 : PENULT;
      default: prg_d = LAST_BANK;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prg_bank <= '0;
      chr_bank <= '0;
    end else begin
      prg_bank <= prg_d;
      chr_bank <= chr_d;
    end
  end
endmodule

// File: rtl/cmd_bank_mapper.sv
module cmd_bank_mapper
  import cbm_pkg::*;
#(
  parameter int DW     = 8,
  parameter int PRG_BW = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        cpu_ahi,
  input  logic              cpu_a0,
  input  logic [DW-1:0]     wr_data,
  input  logic [2:0]        ppu_ahi,
  input  logic              scan_pulse,
  output logic [PRG_BW-1:0] prg_bank,
  output logic [DW-1:0]     chr_bank,
  output logic              mirror_vert,
  output logic              sram_en,
  output logic              irq
);
  mode_t                        mode;
  logic [NUM_BANKS-1:0][DW-1:0] banks;
  logic                         wr_cnt, wr_latch, wr_off, wr_on;

  cbm_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .cpu_ahi(cpu_ahi), .cpu_a0(cpu_a0),
    .wr_data(wr_data), .mode_q(mode), .banks_q(banks), .mirror_q(mirror_vert),
    .sram_q(sram_en), .wr_cnt(wr_cnt), .wr_latch(wr_latch), .wr_off(wr_off),
    .wr_on(wr_on)
  );

  cbm_irq #(.CW(DW)) u_irq (
    .clk(clk), .rst(rst), .wr_cnt(wr_cnt), .wr_latch(wr_latch), .wr_off(wr_off),
    .wr_on(wr_on), .din(wr_data), .tick(scan_pulse), .irq(irq)
  );

  cbm_xlate #(.DW(DW), .PRG_BW(PRG_BW)) u_xlate (
    .clk(clk), .rst(rst), .mode(mode), .banks(banks), .cpu_ahi(cpu_ahi),
    .ppu_ahi(ppu_ahi), .prg_bank(prg_bank), .chr_bank(chr_bank)
  );
endmodule

// File: rtl/cbm_checker.sv
module cbm_checker #(
  parameter int DW     = 8,
  parameter int PRG_BW = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [2:0]        cpu_ahi,
  input logic              cpu_a0,
  input logic [DW-1:0]     wr_data,
  input logic              scan_pulse,
  input logic [PRG_BW-1:0] prg_bank,
  input logic              mirror_vert,
  input logic              sram_en,
  input logic              irq
);
  logic ack;
  assign ack = wr_en && cpu_ahi == 3'b111 && !cpu_a0;

  // R9
  irq_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ack |=> !irq);
  // R9
  irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (irq && !ack) |=> irq);
  // R9
  irq_source_chk: assert property (@(posedge clk) disable iff (rst)
    !scan_pulse |=> !$rose(irq));
  // R5
  last_bank_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_ahi == 3'b111) |=> prg_bank == {PRG_BW{1'b1}});
  // R7
  sram_set_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && cpu_ahi == 3'b101 && cpu_a0) |=> sram_en == $past(wr_data[7]));
  // R10
  ignore_low_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && cpu_ahi[2]) |=> $stable(sram_en) && $stable(mirror_vert));
endmodule

bind cmd_bank_mapper cbm_checker #(.DW(DW), .PRG_BW(PRG_BW)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .cpu_ahi(cpu_ahi), .cpu_a0(cpu_a0),
  .wr_data(wr_data), .scan_pulse(scan_pulse), .prg_bank(prg_bank),
  .mirror_vert(mirror_vert), .sram_en(sram_en), .irq(irq)
);

// File: tb/tb_cmd_bank_mapper.sv
module tb_cmd_bank_mapper;
  logic       clk = 0, rst = 1, wr_en = 0, cpu_a0 = 0, scan_pulse = 0;
  logic [2:0] cpu_ahi = 0, ppu_ahi = 0;
  logic [7:0] wr_data = 0;
  logic [5:0] prg_bank;
  logic [7:0] chr_bank;
  logic       mirror_vert, sram_en, irq;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cmd_bank_mapper dut (.*);

  // behavioural reference model
  int m_bank[8];
  int m_cmd, m_swap, m_inv, m_mir, m_sram, m_cnt, m_lat, m_en, m_irq;
  int e_prg, e_chr;
  bit m_valid = 0;

  function automatic int ref_prg(int win);
    case (win)
      0: return m_swap ? 62 : m_bank[6] % 64;
      1: return m_bank[7] % 64;
      2: return m_swap ? m_bank[6] % 64 : 62;
      default: return 63;
    endcase
  endfunction

  function automatic int ref_chr(int idx);
    int k = (idx * 1024 ^ (m_inv ? 4096 : 0)) / 1024;
    if (k < 2) return (m_bank[0] & ~1) + k;
    if (k < 4) return (m_bank[1] & ~1) + (k - 2);
    return m_bank[k - 2];
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      foreach (m_bank[i]) m_bank[i] = 0;
      m_cmd = 0; m_swap = 0; m_inv = 0; m_mir = 0; m_sram = 0;
      m_cnt = 0; m_lat = 0; m_en = 0; m_irq = 0; e_prg = 0; e_chr = 0;
      m_valid = 1;
    end else begin
      int addr;
      int nx;
      bit w;
      e_prg = ref_prg(int'(cpu_ahi[1:0]));
      e_chr = ref_chr(int'(ppu_ahi));
      w = wr_en && cpu_ahi[2];
      addr = 32768 + int'(cpu_ahi[1:0]) * 8192 + int'(cpu_a0);
      if (w && addr == 'h8000) begin
        m_cmd = wr_data % 8; m_swap = wr_data[6]; m_inv = wr_data[7];
      end
      if (w && addr == 'h8001) m_bank[m_cmd] = wr_data;
      if (w && addr == 'hA000) m_mir = wr_data[1];
      if (w && addr == 'hA001) m_sram = wr_data[7];
      if (w && addr == 'hE000) begin
        m_cnt = m_lat; m_irq = 0;
      end else if (w && addr == 'hC000) m_cnt = wr_data;
      else if (scan_pulse) begin
        nx = (m_cnt == 0) ? m_lat : m_cnt - 1;
        m_cnt = nx;
        if (nx == 0 && m_en == 1) m_irq = 1;
      end
      if (w && addr == 'hC001) m_lat = wr_data;
      if (w && addr == 'hE000) m_en = 0;
      if (w && addr == 'hE001) m_en = 1;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && m_valid && !done) begin
      chk("R5 R6 prg model", int'(prg_bank), e_prg);
      chk("R3 R4 chr model", int'(chr_bank), e_chr);
      chk("R7 mirror model", int'(mirror_vert), m_mir);
      chk("R7 sram model", int'(sram_en), m_sram);
      chk("R8 R9 irq model", int'(irq), m_irq);
    end
  end

  task automatic wr(input logic [2:0] ahi, input logic a0, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; cpu_ahi = ahi; cpu_a0 = a0; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic pulse();
    @(negedge clk); scan_pulse = 1;
    @(negedge clk); scan_pulse = 0;
  endtask

  task automatic peek_prg(input logic [2:0] ahi, input int exp, input string tag);
    @(negedge clk); cpu_ahi = ahi;
    @(negedge clk); chk(tag, int'(prg_bank), exp);
  endtask

  task automatic peek_chr(input logic [2:0] p, input int exp, input string tag);
    @(negedge clk); ppu_ahi = p;
    @(negedge clk); chk(tag, int'(chr_bank), exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 reset prg", int'(prg_bank), 0);
    chk("R1 reset irq", int'(irq), 0);
    chk("R1 reset sram", int'(sram_en), 0);
    chk("R1 reset mirror", int'(mirror_vert), 0);

    // R2: load all eight bank registers
    for (int c = 0; c < 8; c++) begin
      int v;
      case (c)
        0: v = 'h11; 1: v = 'h25; 2: v = 'h30; 3: v = 'h31;
        4: v = 'h32; 5: v = 'h33; 6: v = 'h05; default: v = 'h09;
      endcase
      wr(3'b100, 0, 8'(c));
      wr(3'b100, 1, 8'(v));
    end
    peek_chr(3'd0, 'h10, "R3 cmd0 low half even");
    peek_chr(3'd1, 'h11, "R3 cmd0 high half");
    peek_chr(3'd2, 'h24, "R3 cmd1 low half");
    peek_chr(3'd3, 'h25, "R3 cmd1 high half");
    peek_chr(3'd4, 'h30, "R4 cmd2 window");
    peek_chr(3'd7, 'h33, "R4 cmd5 window");
    peek_prg(3'b100, 5,  "R5 8000 cmd6");
    peek_prg(3'b101, 9,  "R5 A000 cmd7");
    peek_prg(3'b110, 62, "R5 C000 second-to-last");
    peek_prg(3'b111, 63, "R5 E000 last");

    // both mode bits set, command 0
    wr(3'b100, 0, 8'hC0);
    peek_chr(3'd0, 'h30, "R4 inverted index0");
    peek_chr(3'd4, 'h10, "R4 inverted index4");
    peek_prg(3'b100, 62, "R5 swapped 8000");
    peek_prg(3'b110, 5,  "R5 swapped C000");
    wr(3'b100, 1, 8'h44);
    peek_chr(3'd4, 'h44, "R2 data write to cmd0");
    peek_chr(3'd5, 'h45, "R2 cmd0 upper half");
    peek_chr(3'd1, 'h31, "R2 cmd3 untouched");

    // R10: writes with A15 low
    wr(3'b000, 1, 8'hFF);
    wr(3'b011, 0, 8'hFF);
    wr(3'b001, 1, 8'hFF);
    peek_chr(3'd4, 'h44, "R10 bank kept");
    chk("R10 sram kept", int'(sram_en), 0);
    chk("R10 mirror kept", int'(mirror_vert), 0);

    // R7
    wr(3'b101, 0, 8'h02);
    chk("R7 mirror set", int'(mirror_vert), 1);
    wr(3'b101, 0, 8'h01);
    chk("R7 mirror bit0 ignored", int'(mirror_vert), 0);
    wr(3'b101, 1, 8'h80);
    chk("R7 sram set", int'(sram_en), 1);

    // R8 / R9
    wr(3'b110, 1, 8'd3);
    wr(3'b111, 0, 8'd0);
    wr(3'b111, 1, 8'd0);
    pulse(); pulse();
    chk("R9 no irq before zero", int'(irq), 0);
    pulse();
    chk("R9 irq at zero", int'(irq), 1);
    pulse();
    chk("R9 irq held after reload", int'(irq), 1);
    wr(3'b111, 0, 8'd0);
    chk("R9 irq cleared", int'(irq), 0);
    pulse(); pulse(); pulse();
    chk("R8 disabled countdown no irq", int'(irq), 0);
    wr(3'b110, 0, 8'd1);
    wr(3'b111, 1, 8'd0);
    pulse();
    chk("R8 direct counter load irq", int'(irq), 1);
    wr(3'b111, 0, 8'd0);
    chk("R9 final clear", int'(irq), 0);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule